// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a small set of peripheral request lines and a processor. It records new requests as pending, chooses which one the processor should take, and keeps one bit per source for every handler that has been entered but not yet finished. That bit set works as the in-service stack. The processor sees an interrupt line and a vector ID. It confirms a grant with an acknowledge pulse and signals the end of a handler with an end-of-handler pulse. A read-only view of the current handler tells the processor which routine is running or has just resumed.

There are three sources by default. Index 0 has priority 3 (printer), index 1 has priority 5 (disk) and index 2 has priority 7 (communication line). A higher index always outranks a lower one, and the vector ID is the source index. A mode input picks one of two policies. In sequential mode, no handler is interrupted. In nested mode, a strictly higher request pre-empts the running handler. When a handler ends, the next grant comes from the same comparison against what is left on the stack. A pending request that outranks the handler underneath is therefore taken before that handler resumes.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After synchronous active-high reset, the interrupt output is low, no handler is in service (active-valid low) and no request is pending.
- R2: A rising edge on a request line makes that source pending. While the interrupt line is low and a pending source is eligible, the interrupt line rises and the vector ID gives the highest pending index (index 2 above 1 above 0).
- R3: While the interrupt line is high and no acknowledge arrives, the interrupt line stays high and the vector ID does not change, even when a higher request appears.
- R4: An acknowledge while the interrupt line is high drops the line on the next cycle. It clears that source's pending flag and marks the source in service. A request held high does not make the source pending again.
- R5: In sequential mode (mode input 0), the interrupt line does not rise while any handler is in service. Requests that arrive meanwhile stay pending and are granted after the last handler ends.
- R6: In nested mode (mode input 1), a pending request with a higher index than the current handler raises the interrupt line, and the pre-empted handler stays in service beneath it.
- R7: In nested mode, a pending request whose index is not above the current handler is held until that handler ends.
- R8: End-of-handler clears the highest in-service bit. A pending request that then outranks the next remaining handler is granted first. Otherwise the active ID reports the resumed handler.
- R9: End-of-handler with no handler in service has no effect on any state.
- R10: Nested order printer, communication (pre-empts), disk (held) ends with communication done, then disk served, then printer resumed, then idle.
- R11: With no handler in service and nothing pending, the interrupt line is low and active-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| nested_i | input | 1 | Policy: 0 sequential, 1 nested |
| req_i | input | NSRC | Request lines; bit index is priority rank |
| ack_i | input | 1 | Processor accepts the presented vector |
| eoh_i | input | 1 | Current handler has finished |
| irq_o | output | 1 | Interrupt to the processor |
| vec_id_o | output | IDW | Source index of the presented interrupt |
| active_vld_o | output | 1 | Some handler is in service |
| active_id_o | output | IDW | Index of the current (highest) in-service handler |

## Verification
The bench targets the moment a handler ends while a held request waits. A controller that always resumes the stacked handler would leave the disk request unserved until the printer finished. One that ignored the stack would lose the printer entirely. It also presents a higher request while a vector is still unacknowledged: a design that re-picks the winner would switch the ID under the processor. Other cases are end-of-handler with an empty stack, which a careless design would treat as a pop of garbage, and a request line held high through acknowledge, which a level-sensitive design would re-grant at once. Sequential mode is checked for the opposite error, a pre-emption where none is allowed.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

    typedef enum logic {
        POLICY_SEQ  = 1'b0,
        POLICY_NEST = 1'b1
    } policy_e;

endpackage

// File: rtl/nest_irq_pending.sv
module nest_irq_pending #(
    parameter int NSRC = 3,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] req_i,
    input  logic            clr_vld_i,
    input  logic [IDW-1:0]  clr_idx_i,
    output logic [NSRC-1:0] pend_o
);

    typedef struct packed {
        logic [NSRC-1:0] req_prev;
        logic [NSRC-1:0] pend;
    } pend_state_t;

    pend_state_t st_q, st_d;

    always_comb begin
        st_d          = st_q;
        st_d.req_prev = req_i;
        if (clr_vld_i) begin
            st_d.pend[clr_idx_i] = 1'b0;
        end
        st_d.pend = st_d.pend | (req_i & ~st_q.req_prev);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    // R4: a granted source is no longer pending unless its line rose anew
    p_ack_clears_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_vld_i && !req_i[clr_idx_i]) |=> !pend_o[$past(clr_idx_i)]);

endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack #(
    parameter int NSRC = 3,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            push_vld_i,
    input  logic [IDW-1:0]  push_idx_i,
    input  logic            pop_i,
    output logic [NSRC-1:0] isr_o,
    output logic            top_vld_o,
    output logic [IDW-1:0]  top_idx_o
);

    typedef struct packed {
        logic [NSRC-1:0] isr;
    } stk_state_t;

    stk_state_t st_q, st_d;
    logic [NSRC-1:0] top_mask;

    always_comb begin
        top_vld_o = 1'b0;
        top_idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (st_q.isr[i]) begin
                top_vld_o = 1'b1;
                top_idx_o = IDW'(i);
            end
        end
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_mask
            assign top_mask[g] = top_vld_o && (top_idx_o == IDW'(g));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (pop_i && top_vld_o) begin
            st_d.isr = st_d.isr & ~top_mask;
        end
        if (push_vld_i) begin
            st_d.isr[push_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign isr_o = st_q.isr;

    // R9: end-of-handler on an empty stack leaves it empty
    p_eoh_ignored_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (pop_i && (isr_o == '0) && !push_vld_i) |=> (isr_o == '0));

    // R4: an accepted source appears in service on the next cycle
    p_push_marks_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        push_vld_i |=> isr_o[$past(push_idx_i)]);

    // R8: a pop removes exactly one handler when one is present
    p_pop_one_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (pop_i && top_vld_o && !push_vld_i) |=>
            ($countones(isr_o) == $countones($past(isr_o)) - 1));

endmodule

// File: rtl/nest_irq_select.sv
module nest_irq_select
    import nest_irq_pkg::*;
#(
    parameter int NSRC = 3,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  policy_e         policy_i,
    input  logic [NSRC-1:0] pend_i,
    input  logic            top_vld_i,
    input  logic [IDW-1:0]  top_idx_i,
    output logic            grant_vld_o,
    output logic [IDW-1:0]  grant_idx_o
);

    logic           pend_any;
    logic [IDW-1:0] pend_idx;

    always_comb begin
        pend_any = 1'b0;
        pend_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i]) begin
                pend_any = 1'b1;
                pend_idx = IDW'(i);
            end
        end
    end

    always_comb begin
        grant_idx_o = pend_idx;
        if (!pend_any) begin
            grant_vld_o = 1'b0;
        end else if (!top_vld_i) begin
            grant_vld_o = 1'b1;
        end else if (policy_i == POLICY_NEST) begin
            grant_vld_o = (pend_idx > top_idx_i);
        end else begin
            grant_vld_o = 1'b0;
        end
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nest_irq_pkg::*;
#(
    parameter int NSRC = 3,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            nested_i,
    input  logic [NSRC-1:0] req_i,
    input  logic            ack_i,
    input  logic            eoh_i,
    output logic            irq_o,
    output logic [IDW-1:0]  vec_id_o,
    output logic            active_vld_o,
    output logic [IDW-1:0]  active_id_o
);

    typedef struct packed {
        logic           irq;
        logic [IDW-1:0] id;
    } cpu_state_t;

    cpu_state_t cpu_q, cpu_d;

    policy_e         policy;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] isr;
    logic            top_vld;
    logic [IDW-1:0]  top_idx;
    logic            grant_vld;
    logic [IDW-1:0]  grant_idx;
    logic            accept;

    assign policy = nested_i ? POLICY_NEST : POLICY_SEQ;
    assign accept = cpu_q.irq && ack_i;

    nest_irq_pending #(.NSRC(NSRC)) u_pend (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .req_i     (req_i),
        .clr_vld_i (accept),
        .clr_idx_i (cpu_q.id),
        .pend_o    (pend)
    );

    nest_irq_stack #(.NSRC(NSRC)) u_stack (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .push_vld_i (accept),
        .push_idx_i (cpu_q.id),
        .pop_i      (eoh_i),
        .isr_o      (isr),
        .top_vld_o  (top_vld),
        .top_idx_o  (top_idx)
    );

    nest_irq_select #(.NSRC(NSRC)) u_sel (
        .policy_i    (policy),
        .pend_i      (pend),
        .top_vld_i   (top_vld),
        .top_idx_i   (top_idx),
        .grant_vld_o (grant_vld),
        .grant_idx_o (grant_idx)
    );

    always_comb begin
        cpu_d = cpu_q;
        if (accept) begin
            cpu_d.irq = 1'b0;
        end else if (!cpu_q.irq && grant_vld) begin
            cpu_d.irq = 1'b1;
            cpu_d.id  = grant_idx;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cpu_q <= '0;
        end else begin
            cpu_q <= cpu_d;
        end
    end

    assign irq_o        = cpu_q.irq;
    assign vec_id_o     = cpu_q.id;
    assign active_vld_o = top_vld;
    assign active_id_o  = top_idx;

    // R3: presented vector is held until accepted
    p_id_stable_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !ack_i) |=> (irq_o && $stable(vec_id_o)));

    // R4: acceptance withdraws the interrupt
    p_ack_drop_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && ack_i) |=> !irq_o);

    // R5: sequential policy never interrupts a running handler
    p_seq_mask_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(irq_o) && !$past(nested_i)) |-> !$past(active_vld_o));

    // R6: a raised interrupt during a handler always outranks it
    p_preempt_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(irq_o) && $past(active_vld_o)) |-> (vec_id_o > $past(active_id_o)));

endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;

    localparam int NSRC = 3;
    localparam int IDW  = 2;

    logic            clk = 1'b0;
    logic            rst;
    logic            nested;
    logic [NSRC-1:0] req;
    logic            ack;
    logic            eoh;
    logic            irq;
    logic [IDW-1:0]  vec_id;
    logic            act_vld;
    logic [IDW-1:0]  act_id;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl #(.NSRC(NSRC)) u0 (
        .clk_i        (clk),
        .rst_i        (rst),
        .nested_i     (nested),
        .req_i        (req),
        .ack_i        (ack),
        .eoh_i        (eoh),
        .irq_o        (irq),
        .vec_id_o     (vec_id),
        .active_vld_o (act_vld),
        .active_id_o  (act_id)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input bit exp_irq, input int exp_id);
        check(irq == exp_irq, {tag, " irq"}, int'(irq), int'(exp_irq));
        if (exp_irq) check(vec_id == IDW'(exp_id), {tag, " vec_id"}, int'(vec_id), exp_id);
    endtask

    task automatic chk_act(input string tag, input bit exp_vld, input int exp_id);
        check(act_vld == exp_vld, {tag, " active_vld"}, int'(act_vld), int'(exp_vld));
        if (exp_vld) check(act_id == IDW'(exp_id), {tag, " active_id"}, int'(act_id), exp_id);
    endtask

    task automatic raise(input int idx);
        req[idx] = 1'b1;
        tick(3);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        tick(2);
    endtask

    task automatic do_eoh();
        eoh = 1'b1;
        tick(1);
        eoh = 1'b0;
        tick(2);
    endtask

    task automatic reset_all();
        rst = 1'b1; req = '0; ack = 1'b0; eoh = 1'b0;
        tick(2);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        reset_all();
        chk_irq("R1 reset", 1'b0, 0);
        chk_act("R1 reset", 1'b0, 0);
        tick(3);
        chk_irq("R11 idle", 1'b0, 0);
    endtask

    task automatic t_two_at_once();
        reset_all();
        nested = 1'b1;
        req = 3'b011;
        tick(3);
        chk_irq("R2 highest of two", 1'b1, 1);
        do_ack();
        chk_irq("R7 lower held", 1'b0, 0);
        chk_act("R4 in service", 1'b1, 1);
        do_eoh();
        chk_irq("R8 held one granted", 1'b1, 0);
        do_ack();
        chk_irq("R4 held level no regrant", 1'b0, 0);
        do_eoh();
        chk_act("R11 back to idle", 1'b0, 0);
        chk_irq("R11 back to idle", 1'b0, 0);
        req = '0;
    endtask

    task automatic t_hold_id();
        reset_all();
        nested = 1'b1;
        raise(0);
        chk_irq("R2 single", 1'b1, 0);
        raise(2);
        chk_irq("R3 id held", 1'b1, 0);
        do_ack();
        chk_irq("R6 higher after ack", 1'b1, 2);
        chk_act("R4 printer in service", 1'b1, 0);
        do_ack();
        chk_act("R6 comm on top", 1'b1, 2);
        do_eoh();
        chk_act("R8 printer resumed", 1'b1, 0);
        do_eoh();
        req = '0;
    endtask

    task automatic t_eoh_empty();
        reset_all();
        nested = 1'b0;
        do_eoh();
        chk_act("R9 empty stays empty", 1'b0, 0);
        chk_irq("R9 no irq", 1'b0, 0);
        raise(0);
        eoh = 1'b1;
        tick(1);
        eoh = 1'b0;
        tick(1);
        chk_irq("R9 eoh leaves pending grant", 1'b1, 0);
        do_ack();
        chk_act("R9 grant still taken", 1'b1, 0);
        do_eoh();
        req = '0;
    endtask

    task automatic t_sequential();
        reset_all();
        nested = 1'b0;
        raise(0);
        do_ack();
        chk_act("R5 printer running", 1'b1, 0);
        raise(2);
        chk_irq("R5 no preempt", 1'b0, 0);
        tick(4);
        chk_irq("R5 still masked", 1'b0, 0);
        do_eoh();
        chk_irq("R5 pending served after end", 1'b1, 2);
        do_ack();
        do_eoh();
        chk_act("R5 idle", 1'b0, 0);
        req = '0;
    endtask

    task automatic t_nested_order();
        reset_all();
        nested = 1'b1;
        raise(0);
        chk_irq("R10 printer raised", 1'b1, 0);
        do_ack();
        raise(2);
        chk_irq("R10 comm preempts", 1'b1, 2);
        do_ack();
        chk_act("R10 comm running", 1'b1, 2);
        raise(1);
        chk_irq("R10 disk held", 1'b0, 0);
        do_eoh();
        chk_irq("R10 disk before printer", 1'b1, 1);
        do_ack();
        chk_act("R10 disk running", 1'b1, 1);
        do_eoh();
        chk_act("R10 printer resumes", 1'b1, 0);
        chk_irq("R10 nothing new", 1'b0, 0);
        do_eoh();
        chk_act("R10 user program", 1'b0, 0);
        chk_irq("R10 user program", 1'b0, 0);
        req = '0;
    endtask

    initial begin
        nested = 1'b0;
        t_reset();
        t_two_at_once();
        t_hold_id();
        t_eoh_empty();
        t_sequential();
        t_nested_order();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule